// File: doc/BRIEF.md
# Single-Cycle 32-Bit RISC Subset Core

This block is a compact 32-bit load/store processor that completes one instruction per clock. It holds 32 general registers, with register 0 fixed at zero. Instruction memory sits inside the block and is filled through a write port while reset is held. Data memory is also internal and is cleared by reset. The core fetches from the program counter, decodes one of three fixed 32-bit formats, and executes in the same cycle. It then writes back to the register file or data memory and moves the program counter.

The supported subset covers these instructions:
- register arithmetic and logic: add, sub, and, or, nor and signed set-less-than
- logical shifts left and right by an immediate amount
- immediate add
- word load and store
- equal and not-equal conditional branches
- an absolute jump and a jump through a register

Any other encoding stops the core. It raises a halt flag, holds the program counter and suppresses all writes. A debug read port lets the surrounding logic inspect any register without disturbing execution.

Top module: `mini_risc_core`

## Requirements
- R1: Synchronous reset forces the program counter to 0, clears every general register and clears every data memory word; instruction memory keeps its contents.
- R2: Register 0 reads as zero on every read port, even after an instruction names it as destination.
- R3: An instruction with opcode bits [31:26] = 0 takes rs from [25:21], rt from [20:16] and writes rd [15:11]. The operation is selected by funct [5:0]: add=32, sub=34, and=36, or=37, nor=39 (NOT(rs OR rt)), slt=42 (1 when rs < rt as signed values, else 0).
- R4: funct 0 (shift left) and funct 2 (shift right) shift rt by shamt [10:6] and fill the vacated positions with zeros. The result goes to rd.
- R5: Opcode 8 writes rs plus the sign-extended 16-bit constant [15:0] into rt.
- R6: Opcode 35 loads rt from the data word at rs + sign-extended offset. Opcode 43 stores rt there. Memory is word-addressed by address bits [N+1:2].
- R7: Opcode 4 branches when rs equals rt, and opcode 5 branches when they differ. A taken branch moves the program counter to PC+4 + (sign-extended offset × 4). Otherwise the program counter moves to PC+4.
- R8: Opcode 2 jumps to {PC+4[31:28], target[25:0], 00}. Funct 8 with opcode 0 loads the program counter with the value of rs.
- R9: Any other opcode, or an opcode-0 funct not listed in R3, R4 or R8, raises halt. The program counter then holds its value, and neither registers nor data memory are written.
- R10: Instruction memory word imem_waddr takes imem_wdata on a clock with imem_we high, and is fetched at word index PC[N+1:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_we | input | 1 | Instruction memory write strobe |
| imem_waddr | input | $clog2(IMEM_WORDS) | Instruction memory word index to write |
| imem_wdata | input | 32 | Instruction word to write |
| dbg_raddr | input | 5 | Register number for the debug read |
| dbg_rdata | output | 32 | Contents of register dbg_raddr |
| pc | output | 32 | Current program counter (byte address) |
| halt | output | 1 | High while the fetched instruction is not recognised |

## Verification
The core is exercised with four kinds of program:
- A straight-line arithmetic sequence. Its operand values are chosen so that and, or, nor and sub give distinct bit patterns, and so that a negative operand tells signed from unsigned comparison in slt. It also writes to register 0.
- A counted loop that stores a running sum and reads it back through negative offsets. This tells correct backward branch arithmetic and address formation from near misses.
- A control-flow program mixing taken and untaken beq/bne with j and jr. Skipped instructions would leave visible marks if a wrong target were taken.
- Unknown encodings, and a reset between programs. These show that halt freezes the core and that reset clears registers and data memory but not the program.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_JUMP  = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;

  localparam logic [5:0] FN_SHL  = 6'd0;
  localparam logic [5:0] FN_SHR  = 6'd2;
  localparam logic [5:0] FN_JREG = 6'd8;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_SUB  = 6'd34;
  localparam logic [5:0] FN_AND  = 6'd36;
  localparam logic [5:0] FN_OR   = 6'd37;
  localparam logic [5:0] FN_NOR  = 6'd39;
  localparam logic [5:0] FN_SLT  = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLT, ALU_SHL, ALU_SHR
  } alu_op_e;

  typedef struct packed {
    alu_op_e alu_op;
    logic    use_imm;
    logic    dst_rd;
    logic    rf_we;
    logic    mem_rd;
    logic    mem_wr;
    logic    br_eq;
    logic    br_ne;
    logic    jump;
    logic    jump_reg;
    logic    illegal;
  } ctrl_t;

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] alu_calc(input alu_op_e op, input logic [31:0] a,
                                           input logic [31:0] b, input logic [4:0] sh);
    logic [31:0] y;
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_NOR: y = ~(a | b);
      ALU_SLT: y = {31'd0, ($signed(a) < $signed(b))};
      ALU_SHL: y = b << sh;
      default: y = b >> sh;
    endcase
    return y;
  endfunction

  function automatic logic [31:0] branch_dest(input logic [31:0] pc4, input logic [31:0] off);
    return pc4 + {off[29:0], 2'b00};
  endfunction

  function automatic logic [31:0] jump_dest(input logic [31:0] pc4, input logic [25:0] tgt);
    return {pc4[31:28], tgt, 2'b00};
  endfunction

endpackage

// File: rtl/core_wordmem.sv
module core_wordmem #(
  parameter int WORDS        = 64,
  parameter int WIDTH        = 32,
  parameter bit CLEAR_ON_RST = 1'b0,
  localparam int AW          = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [WORDS];

  generate
    if (CLEAR_ON_RST) begin : g_clear
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we) begin
          mem[waddr] <= wdata;
        end
      end
    end else begin : g_keep
      always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
      end
    end
  endgenerate

  assign rdata = mem[raddr];

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int NREGS = 32,
  parameter int WIDTH = 32,
  localparam int RW   = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RW-1:0]    ra_a,
  input  logic [RW-1:0]    ra_b,
  input  logic [RW-1:0]    ra_c,
  output logic [WIDTH-1:0] rd_a,
  output logic [WIDTH-1:0] rd_b,
  output logic [WIDTH-1:0] rd_c,
  input  logic             we,
  input  logic [RW-1:0]    wa,
  input  logic [WIDTH-1:0] wd
);

  logic [WIDTH-1:0] regs [NREGS];

  assign regs[0] = '0;

  generate
    for (genvar i = 1; i < NREGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)                         regs[i] <= '0;
        else if (we && wa == RW'(i))     regs[i] <= wd;
      end
    end
  endgenerate

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
  assign rd_c = regs[ra_c];

endmodule

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);

  logic [5:0] opcode, funct;
  assign opcode = instr[31:26];
  assign funct  = instr[5:0];

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.rf_we  = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_NOR:  ctrl.alu_op = ALU_NOR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          FN_SHL:  ctrl.alu_op = ALU_SHL;
          FN_SHR:  ctrl.alu_op = ALU_SHR;
          FN_JREG: begin
            ctrl.rf_we    = 1'b0;
            ctrl.jump_reg = 1'b1;
          end
          default: begin
            ctrl.rf_we   = 1'b0;
            ctrl.illegal = 1'b1;
          end
        endcase
      end
      OP_ADDI: begin
        ctrl.use_imm = 1'b1;
        ctrl.rf_we   = 1'b1;
      end
      OP_LOAD: begin
        ctrl.use_imm = 1'b1;
        ctrl.rf_we   = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OP_STORE: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_wr  = 1'b1;
      end
      OP_BEQ:  ctrl.br_eq = 1'b1;
      OP_BNE:  ctrl.br_ne = 1'b1;
      OP_JUMP: ctrl.jump  = 1'b1;
      default: ctrl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/mini_risc_core.sv
module mini_risc_core
  import core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW       = $clog2(IMEM_WORDS),
  localparam int DAW       = $clog2(DMEM_WORDS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           imem_we,
  input  logic [IAW-1:0] imem_waddr,
  input  logic [31:0]    imem_wdata,
  input  logic [4:0]     dbg_raddr,
  output logic [31:0]    dbg_rdata,
  output logic [31:0]    pc,
  output logic           halt
);

  logic [31:0] pc_q, pc_plus4, pc_next;
  logic [31:0] instr, rs_val, rt_val, imm_sext;
  logic [31:0] alu_b, alu_y, dm_rdata, wb_data;
  logic [4:0]  rs_idx, rt_idx, rd_idx, shamt, rf_waddr;
  ctrl_t       ctrl;
  logic        rf_we, dm_we, br_taken, redirect;

  // fetch
  core_wordmem #(.WORDS(IMEM_WORDS), .WIDTH(32), .CLEAR_ON_RST(1'b0)) u_imem (
    .clk   (clk),
    .rst   (rst),
    .we    (imem_we),
    .waddr (imem_waddr),
    .wdata (imem_wdata),
    .raddr (pc_q[IAW+1:2]),
    .rdata (instr)
  );

  // field split
  assign rs_idx   = instr[25:21];
  assign rt_idx   = instr[20:16];
  assign rd_idx   = instr[15:11];
  assign shamt    = instr[10:6];
  assign imm_sext = sext16(instr[15:0]);

  core_decode u_dec (
    .instr (instr),
    .ctrl  (ctrl)
  );

  assign rf_we    = ctrl.rf_we;
  assign rf_waddr = ctrl.dst_rd ? rd_idx : rt_idx;

  core_regfile #(.NREGS(32), .WIDTH(32)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .ra_a (rs_idx),
    .ra_b (rt_idx),
    .ra_c (dbg_raddr),
    .rd_a (rs_val),
    .rd_b (rt_val),
    .rd_c (dbg_rdata),
    .we   (rf_we),
    .wa   (rf_waddr),
    .wd   (wb_data)
  );

  // execute
  assign alu_b = ctrl.use_imm ? imm_sext : rt_val;
  assign alu_y = alu_calc(ctrl.alu_op, rs_val, alu_b, shamt);

  assign dm_we = ctrl.mem_wr;

  core_wordmem #(.WORDS(DMEM_WORDS), .WIDTH(32), .CLEAR_ON_RST(1'b1)) u_dmem (
    .clk   (clk),
    .rst   (rst),
    .we    (dm_we),
    .waddr (alu_y[DAW+1:2]),
    .wdata (rt_val),
    .raddr (alu_y[DAW+1:2]),
    .rdata (dm_rdata)
  );

  assign wb_data = ctrl.mem_rd ? dm_rdata : alu_y;

  // next pc
  assign pc_plus4 = pc_q + 32'd4;
  assign br_taken = (ctrl.br_eq && (rs_val == rt_val)) ||
                    (ctrl.br_ne && (rs_val != rt_val));
  assign redirect = br_taken || ctrl.jump || ctrl.jump_reg;

  always_comb begin
    if (ctrl.illegal)       pc_next = pc_q;
    else if (ctrl.jump_reg) pc_next = rs_val;
    else if (ctrl.jump)     pc_next = jump_dest(pc_plus4, instr[25:0]);
    else if (br_taken)      pc_next = branch_dest(pc_plus4, imm_sext);
    else                    pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc   = pc_q;
  assign halt = ctrl.illegal;

  logic unused_bits;
  assign unused_bits = ^{pc_q[31:IAW+2], pc_q[1:0], alu_y[31:DAW+2], alu_y[1:0]};

endmodule

// File: rtl/mini_risc_core_chk.sv
module mini_risc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic        halt,
  input logic [4:0]  rs_idx,
  input logic [31:0] rs_val,
  input logic        rf_we,
  input logic        dm_we,
  input logic        br_taken,
  input logic        redirect,
  input logic [31:0] imm_sext
);

  // R1: reset always returns the program counter to zero
  p_reset_pc_r1: assert property (@(posedge clk) rst |=> (pc == 32'd0));

  // R2: reading register 0 through the operand port yields zero
  p_zero_reg_r2: assert property (@(posedge clk) disable iff (rst)
    (rs_idx == 5'd0) |-> (rs_val == 32'd0));

  // R7: no redirect means the next fetch is one word further
  p_seq_pc_r7: assert property (@(posedge clk) disable iff (rst)
    (!halt && !redirect) |=> (pc == $past(pc) + 32'd4));

  // R7: taken branch lands on PC+4 plus the scaled offset
  p_branch_dest_r7: assert property (@(posedge clk) disable iff (rst)
    (br_taken && !halt) |=> (pc == $past(pc + 32'd4 + {imm_sext[29:0], 2'b00})));

  // R9: a halted core holds its program counter
  p_halt_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    halt |=> $stable(pc));

  // R9: a halted core writes neither registers nor data memory
  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    halt |-> (!rf_we && !dm_we));

endmodule

bind mini_risc_core mini_risc_core_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc_q),
  .halt     (halt),
  .rs_idx   (rs_idx),
  .rs_val   (rs_val),
  .rf_we    (rf_we),
  .dm_we    (dm_we),
  .br_taken (br_taken),
  .redirect (redirect),
  .imm_sext (imm_sext)
);

// File: tb/sim_mini_risc_core.sv
module sim_mini_risc_core;

  localparam int IW  = 64;
  localparam int IAW = $clog2(IW);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           imem_we = 1'b0;
  logic [IAW-1:0] imem_waddr = '0;
  logic [31:0]    imem_wdata = '0;
  logic [4:0]     dbg_raddr = '0;
  logic [31:0]    dbg_rdata;
  logic [31:0]    pc;
  logic           halt;

  int tests_run = 0;
  int tests_failed = 0;

  logic [31:0] prog [IW];
  int          plen;

  always #10 clk = ~clk;

  mini_risc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(64)) u0 (
    .clk, .rst, .imem_we, .imem_waddr, .imem_wdata,
    .dbg_raddr, .dbg_rdata, .pc, .halt
  );

  localparam logic [31:0] BAD_OP = 32'hFC00_0000;

  function automatic logic [31:0] r_ins(input logic [5:0] fn, input int rs, input int rt,
                                        input int rd, input int sh);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn};
  endfunction

  function automatic logic [31:0] i_ins(input logic [5:0] op, input int rs, input int rt,
                                        input int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  function automatic logic [31:0] j_ins(input logic [5:0] op, input int tgt);
    return {op, tgt[25:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_is(input string tag, input int idx, input logic [31:0] exp);
    dbg_raddr = idx[4:0];
    #1;
    chk(tag, dbg_rdata, exp);
  endtask

  // holds reset, writes the program, releases reset and runs
  task automatic load_and_run(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < plen; i++) begin
      imem_we    = 1'b1;
      imem_waddr = IAW'(i);
      imem_wdata = prog[i];
      @(negedge clk);
    end
    imem_we = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 pc at reset", pc, 32'd0);
    reg_is("R1 r2 at reset", 2, 32'd0);
    reg_is("R1 r31 at reset", 31, 32'd0);
  endtask

  task automatic t_alu();
    logic [31:0] a, b;
    a = 32'h3C00; b = 32'h0DC0;
    prog[0]  = i_ins(6'd8, 0, 1, 'h3C00);
    prog[1]  = i_ins(6'd8, 0, 2, 'h0DC0);
    prog[2]  = r_ins(6'd36, 1, 2, 3, 0);
    prog[3]  = r_ins(6'd37, 1, 2, 4, 0);
    prog[4]  = r_ins(6'd39, 1, 0, 5, 0);
    prog[5]  = r_ins(6'd34, 2, 1, 6, 0);
    prog[6]  = i_ins(6'd8, 0, 7, -5);
    prog[7]  = r_ins(6'd42, 7, 1, 8, 0);
    prog[8]  = r_ins(6'd42, 1, 7, 9, 0);
    prog[9]  = r_ins(6'd0, 0, 1, 10, 4);
    prog[10] = r_ins(6'd2, 0, 5, 11, 28);
    prog[11] = i_ins(6'd8, 0, 0, 77);
    prog[12] = r_ins(6'd32, 1, 2, 12, 0);
    prog[13] = BAD_OP;
    plen = 14;
    load_and_run(20);
    reg_is("R5 addi positive", 1, a);
    reg_is("R3 and", 3, a & b);
    reg_is("R3 or", 4, a | b);
    reg_is("R3 nor with r0", 5, ~a);
    reg_is("R3 sub negative", 6, b - a);
    reg_is("R5 addi sign-extended", 7, 32'hFFFF_FFFB);
    reg_is("R3 slt signed true", 8, 32'd1);
    reg_is("R3 slt signed false", 9, 32'd0);
    reg_is("R4 shift left", 10, a << 4);
    reg_is("R4 shift right zero fill", 11, 32'h0000_000F);
    reg_is("R2 write to r0 ignored", 0, 32'd0);
    reg_is("R3 add", 12, a + b);
    chk("R9 halt on bad opcode", {31'd0, halt}, 32'd1);
    chk("R9 pc at bad opcode", pc, 32'd52);
    repeat (5) @(negedge clk);
    chk("R9 pc frozen", pc, 32'd52);
  endtask

  task automatic t_loop_mem();
    prog[0]  = i_ins(6'd8, 0, 1, 5);
    prog[1]  = i_ins(6'd8, 0, 2, 0);
    prog[2]  = i_ins(6'd8, 0, 3, 64);
    prog[3]  = r_ins(6'd32, 2, 1, 2, 0);
    prog[4]  = i_ins(6'd43, 3, 2, 0);
    prog[5]  = i_ins(6'd8, 3, 3, 4);
    prog[6]  = i_ins(6'd8, 1, 1, -1);
    prog[7]  = i_ins(6'd5, 1, 0, -5);
    prog[8]  = i_ins(6'd35, 3, 4, -4);
    prog[9]  = i_ins(6'd35, 3, 5, -20);
    prog[10] = BAD_OP;
    plen = 11;
    load_and_run(40);
    reg_is("R7 loop counter reached zero", 1, 32'd0);
    reg_is("R7 loop sum", 2, 32'd15);
    reg_is("R6 pointer after stores", 3, 32'd84);
    reg_is("R6 load last stored word", 4, 32'd15);
    reg_is("R6 load first stored word", 5, 32'd5);
    chk("R7 pc after loop", pc, 32'd40);
  endtask

  task automatic t_flow();
    prog[0]  = i_ins(6'd8, 0, 1, 7);
    prog[1]  = i_ins(6'd4, 1, 0, 5);
    prog[2]  = i_ins(6'd4, 0, 0, 2);
    prog[3]  = i_ins(6'd8, 0, 2, 1);
    prog[4]  = i_ins(6'd8, 0, 2, 2);
    prog[5]  = j_ins(6'd2, 8);
    prog[6]  = i_ins(6'd8, 0, 3, 1);
    prog[7]  = i_ins(6'd8, 0, 3, 2);
    prog[8]  = i_ins(6'd8, 0, 4, 48);
    prog[9]  = r_ins(6'd8, 4, 0, 0, 0);
    prog[10] = i_ins(6'd8, 0, 5, 1);
    prog[11] = BAD_OP;
    prog[12] = i_ins(6'd8, 0, 6, 9);
    prog[13] = i_ins(6'd5, 6, 6, 3);
    prog[14] = BAD_OP;
    plen = 15;
    load_and_run(20);
    reg_is("R7 beq taken skips words", 2, 32'd0);
    reg_is("R8 jump skips words", 3, 32'd0);
    reg_is("R8 jr skips words", 5, 32'd0);
    reg_is("R8 jr target executed", 6, 32'd9);
    chk("R7 bne untaken reaches end", pc, 32'd56);
  endtask

  task automatic t_bad_funct();
    prog[0] = i_ins(6'd8, 0, 1, 3);
    prog[1] = r_ins(6'd1, 1, 1, 1, 0);
    prog[2] = i_ins(6'd8, 0, 1, 9);
    plen = 3;
    load_and_run(10);
    chk("R9 halt on bad funct", {31'd0, halt}, 32'd1);
    chk("R9 pc held at bad funct", pc, 32'd4);
    reg_is("R9 no write after bad funct", 1, 32'd3);
  endtask

  task automatic t_mem_clear();
    prog[0] = i_ins(6'd35, 0, 2, 64);
    prog[1] = i_ins(6'd8, 0, 1, 1);
    prog[2] = BAD_OP;
    plen = 3;
    load_and_run(10);
    reg_is("R1 data memory cleared by reset", 2, 32'd0);
    reg_is("R10 loaded program ran", 1, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests_failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_alu();
    t_loop_mem();
    t_reset_state();
    t_loop_mem();
    t_mem_clear();
    t_flow();
    t_bad_funct();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule